// File: doc/BRIEF.md
# Square-Wave Timer Channel

This block is one counter channel fixed to square-wave generation. Software writes a 16-bit initial count N, and the channel drives an output whose period is N count pulses. It counts down by two per pulse and toggles the output each time a half period runs out. A count pulse is a one-cycle `tick_i` strobe sampled on the system clock `clk_i`, so the channel needs no clock domain of its own. The count can be kept in plain binary or as four BCD digits.

When N is odd, the waveform is asymmetric. The output is high for (N+1)/2 pulses and low for (N-1)/2 pulses. To get this, the first step after a reload is one when the output is high and three when it is low. All later steps are two.

A gate input controls counting. While the gate is low, counting stops and the output is held high. A rising edge on the gate restarts the waveform from the initial count. A count written while the channel is running is held back until the current half period ends, or until a gate trigger, whichever comes first. Host bus decoding and read latches belong to the surrounding logic.

Top module: `sqwave_timer`

## Requirements
- R1: After reset, `out_o` is 1 and `count_o` is 0. The first `tick_i` after the first count write loads N into the counting element and leaves `out_o` at 1.
- R2: For an even N, `out_o` stays high for N/2 ticks and then low for N/2 ticks, counting from the tick that loads N.
- R3: For an odd N, `out_o` stays high for (N+1)/2 ticks and then low for (N-1)/2 ticks.
- R4: The counting element steps down by 2 on each tick. The exception is the first tick after a reload of an odd value: that tick steps down by 1 while `out_o` is 1, and by 3 while `out_o` is 0. When the next value would be 0, `out_o` toggles and N reloads instead.
- R5: While `gate_i` is 0, `count_o` is held. At the first `clk_i` edge that samples `gate_i` low, `out_o` is forced to 1, and no tick is needed for this.
- R6: Once a `gate_i` 0-to-1 edge has been sampled, the next tick reloads N and sets `out_o` to 1.
- R7: A count written with `load_i` while the channel is running does not change the counting element. It is used at the next half-period reload, or at a gate-triggered reload if one comes first.
- R8: A count of 0 stands for the largest count: 65536 in binary, so 0x0000 steps to 0xFFFE, and 10000 in BCD, so 0x0000 steps to 0x9998.
- R9: With `bcd_i` set to 1, each 4-bit digit of `count_o` counts from 0 to 9, and a step borrows across digits (0x0101 steps by 1 to 0x0100, then by 2 to 0x0098).
- R10: Without `tick_i`, `count_o` does not change. With `gate_i` high and no tick, `out_o` does not change either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count pulse strobe, one cycle wide |
| gate_i | input | 1 | Gate: 1 enables counting, and a rising edge triggers a reload |
| load_i | input | 1 | Write strobe for the initial count |
| count_i | input | CW | Initial count written on `load_i` |
| bcd_i | input | 1 | 1 selects BCD counting, 0 selects binary |
| out_o | output | 1 | Square-wave output |
| count_o | output | CW | Current value of the counting element |

## Verification
Every result of this block is registered, so each one is due at the first `clk_i` rising edge after its cause. For a tick, this is the step or reload of `count_o` and any toggle of `out_o`. For a gate change, it is the forced-high output and the armed trigger. For a write, it is the new count.

The driver raises `tick_i`, `gate_i` or `load_i` at a falling edge and pushes the expected `out_o` and `count_o` in the same step. The monitor pops that entry and compares 2 ns after the following rising edge, which is exactly one register stage later.

High and low durations are checked separately. The bench counts `out_o` samples taken at falling edges over the N ticks that follow a reload.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  typedef logic [1:0] step_t;

  // first step after loading an odd value: 1 in the high half, 3 in the low half
  function automatic step_t pick_step(input logic odd, input logic hi);
    if (!odd) return 2'd2;
    return hi ? 2'd1 : 2'd3;
  endfunction
endpackage

// File: rtl/sqw_trig.sv
module sqw_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic consume_i,
  output logic trig_o
);
  logic gate_q, trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b1;
      trig_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (gate_i && !gate_q)          trig_q <= 1'b1;
      else if (!gate_i || consume_i)  trig_q <= 1'b0;
    end
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/sqw_step.sv
module sqw_step import sqw_pkg::*; #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] ce_i,
  input  step_t         step_i,
  input  logic          bcd_i,
  output logic [CW-1:0] nxt_o,
  output logic          zero_o
);
  localparam int ND = CW / 4;

  logic [1:0]    brw [ND];
  logic [CW-1:0] bcd_nxt, bin_nxt;

  assign brw[0] = step_i;

  // ripple borrow through the decimal digits
  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [4:0] diff;
    assign diff = {1'b0, ce_i[4*g +: 4]} - {3'b000, brw[g]};
    assign bcd_nxt[4*g +: 4] = diff[4] ? diff[3:0] + 4'd10 : diff[3:0];
    if (g < ND - 1) begin : g_chain
      assign brw[g+1] = {1'b0, diff[4]};
    end
  end

  assign bin_nxt = ce_i - CW'(step_i);
  assign nxt_o   = bcd_i ? bcd_nxt : bin_nxt;
  assign zero_o  = (nxt_o == '0);
endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer import sqw_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          load_i,
  input  logic [CW-1:0] count_i,
  input  logic          bcd_i,
  output logic          out_o,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cr_q, ce_q, nxt;
  logic          have_q, running, out_q, trig, zero;
  step_t         step;

  sqw_trig i_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_i    (gate_i),
    .consume_i (tick_i),
    .trig_o    (trig)
  );

  assign step = pick_step(ce_q[0], out_q);

  sqw_step #(.CW(CW)) i_step (
    .ce_i   (ce_q),
    .step_i (step),
    .bcd_i  (bcd_i),
    .nxt_o  (nxt),
    .zero_o (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_q   <= '0;
      have_q <= 1'b0;
    end else if (load_i) begin
      cr_q   <= count_i;
      have_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q    <= '0;
      running <= 1'b0;
    end else if (tick_i) begin
      if (!running) begin
        if (have_q) begin
          ce_q    <= cr_q;
          running <= 1'b1;
        end
      end else if (gate_i) begin
        ce_q <= (trig || zero) ? cr_q : nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       out_q <= 1'b1;
    else if (!gate_i)                  out_q <= 1'b1;
    else if (tick_i && running) begin
      if (trig)                        out_q <= 1'b1;
      else if (zero)                   out_q <= ~out_q;
    end
  end

  assign out_o   = out_q;
  assign count_o = ce_q;
endmodule

// File: rtl/sqw_chk.sv
module sqw_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          gate_i,
  input logic          run_i,
  input logic          out_o,
  input logic [CW-1:0] count_o
);
  p_start_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !run_i) |=> out_o);

  p_gate_forces_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> out_o);

  p_gate_holds_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && run_i) |=> $stable(count_o));

  p_idle_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  p_idle_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && gate_i) |=> $stable(out_o));
endmodule

bind sqwave_timer sqw_chk #(.CW(CW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .gate_i  (gate_i),
  .run_i   (running),
  .out_o   (out_o),
  .count_o (count_o)
);

// File: tb/test_sqwave_timer.sv
`timescale 1ns/1ps
module test_sqwave_timer;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b0, gate_i = 1'b1, load_i = 1'b0, bcd_i = 1'b0;
  logic [15:0] count_i = '0;
  logic out_o;
  logic [15:0] count_o;

  always #10 clk = ~clk;

  sqwave_timer #(.CW(16)) i_sqwave_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .gate_i(gate_i),
    .load_i(load_i), .count_i(count_i), .bcd_i(bcd_i),
    .out_o(out_o), .count_o(count_o)
  );

  typedef struct { logic o; logic [15:0] c; string tag; } exp_t;
  exp_t q[$];
  int errs = 0, checks = 0;
  logic chk = 1'b0;
  string cur = "R1";

  // requirement-level reference state
  logic        m_out = 1'b1, m_run = 1'b0, m_have = 1'b0, m_trig = 1'b0, m_gate = 1'b1, m_bcd = 1'b0;
  logic [15:0] m_ce = '0, m_cr = '0;

  function automatic int bcd2int(logic [15:0] v);
    int r = 0;
    for (int d = 3; d >= 0; d--) r = r * 10 + int'(v[4*d +: 4]);
    return r;
  endfunction

  function automatic logic [15:0] int2bcd(int v);
    logic [15:0] r = '0;
    for (int d = 0; d < 4; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic model_tick();
    int st, v;
    logic [15:0] nx;
    if (!m_run) begin
      if (m_have) begin m_ce = m_cr; m_run = 1'b1; end
    end else if (m_trig && m_gate) begin
      m_ce = m_cr; m_out = 1'b1;
    end else if (m_gate) begin
      st = !m_ce[0] ? 2 : (m_out ? 1 : 3);
      if (m_bcd) begin
        v = bcd2int(m_ce); if (v == 0) v = 10000;
        nx = int2bcd(v - st);
      end else begin
        v = (m_ce == 0) ? 65536 : int'(m_ce);
        nx = 16'(v - st);
      end
      if (nx == 0) begin m_out = ~m_out; m_ce = m_cr; end
      else m_ce = nx;
    end
    m_trig = 1'b0;
  endtask

  task automatic push();
    exp_t e;
    e.o = m_out; e.c = m_ce; e.tag = cur;
    q.push_back(e);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick_i = 1'b1; model_tick(); push(); chk = 1'b1;
    @(negedge clk); tick_i = 1'b0; chk = 1'b0;
  endtask

  task automatic set_gate(logic v);
    @(negedge clk); gate_i = v;
    if (!v) begin m_out = 1'b1; m_trig = 1'b0; end
    else if (!m_gate) m_trig = 1'b1;
    m_gate = v; push(); chk = 1'b1;
    @(negedge clk); chk = 1'b0;
  endtask

  task automatic write_count(logic [15:0] n);
    @(negedge clk); load_i = 1'b1; count_i = n; m_cr = n; m_have = 1'b1; push(); chk = 1'b1;
    @(negedge clk); load_i = 1'b0; chk = 1'b0;
  endtask

  task automatic set_bcd(logic v);
    @(negedge clk); bcd_i = v; m_bcd = v;
  endtask

  task automatic pulse_gate();
    set_gate(1'b0); set_gate(1'b1);
  endtask

  // called right after a reload tick: counts high samples over N ticks
  task automatic measure(int n, int exp_hi, string tag);
    int hi = out_o ? 1 : 0;
    for (int i = 1; i < n; i++) begin do_tick(); hi += out_o ? 1 : 0; end
    check({tag, " high ticks"}, 32'(hi), 32'(exp_hi));
    check({tag, " low ticks"}, 32'(n - hi), 32'(n - exp_hi));
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (chk) begin
      exp_t e;
      #2;
      if (q.size() == 0) begin
        checks++; errs++;
        $display("FAIL %s: actual=queue-empty expected=item", cur);
      end else begin
        e = q.pop_front();
        check(e.tag, {15'd0, out_o, count_o}, {15'd0, e.o, e.c});
      end
    end
  end

  initial begin
    #(20 * 20000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset out", 32'(out_o), 32'd1);
    check("R1 reset count", 32'(count_o), 32'd0);

    cur = "R1"; write_count(16'd4); do_tick();
    check("R1 first load", {15'd0, out_o, count_o}, {15'd0, 1'b1, 16'd4});
    cur = "R2"; measure(4, 2, "R2"); repeat (6) do_tick();
    cur = "R7"; do_tick(); write_count(16'd6); repeat (8) do_tick();
    cur = "R6"; write_count(16'd5); pulse_gate(); do_tick();
    check("R6 trigger reload", {15'd0, out_o, count_o}, {15'd0, 1'b1, 16'd5});
    cur = "R3"; measure(5, 3, "R3");
    cur = "R4"; repeat (6) do_tick();
    cur = "R3"; write_count(16'd7); pulse_gate(); do_tick(); measure(7, 4, "R3");
    cur = "R5";
    for (int i = 0; i < 20 && out_o; i++) do_tick();
    set_gate(1'b0);
    check("R5 forced high", 32'(out_o), 32'd1);
    repeat (3) do_tick();
    cur = "R6"; set_gate(1'b1); do_tick(); repeat (4) do_tick();
    cur = "R7"; write_count(16'd8); do_tick(); pulse_gate(); do_tick();
    check("R7 trigger takes new count", 32'(count_o), 32'd8);
    repeat (3) do_tick();
    cur = "R8"; write_count(16'd0); pulse_gate(); do_tick(); do_tick();
    check("R8 binary zero", 32'(count_o), 32'hFFFE);
    do_tick();
    cur = "R9"; set_bcd(1'b1); write_count(16'h0101); pulse_gate(); do_tick();
    do_tick(); check("R9 bcd step 1", 32'(count_o), 32'h0100);
    do_tick(); check("R9 bcd borrow", 32'(count_o), 32'h0098);
    write_count(16'h0009); pulse_gate(); do_tick(); measure(9, 5, "R9");
    cur = "R8"; write_count(16'h0000); pulse_gate(); do_tick(); do_tick();
    check("R8 bcd zero", 32'(count_o), 32'h9998);
    cur = "R10";
    repeat (5) @(negedge clk);
    check("R10 idle", {15'd0, out_o, count_o}, {15'd0, m_out, m_ce});
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule